// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32.768 kHz tick enable into periodic interrupt events at a programmable power-of-two rate. A free-running tick counter runs for as long as the block is out of reset. An event fires on the tick that carries the counter onto a multiple of the selected period, so events stay phase-aligned to that count. They are not aligned to the moment the rate was written. The host decodes the register bus and supplies the 4-bit rate code and the periodic-enable bit. The block returns a one-cycle event pulse, two sticky status flags and an interrupt request.

The rate code is decoded with an alias: codes 1 and 2 give the slow periods of codes 8 and 9, and not the fast ones their value suggests. A status-clear strobe, raised when the host reads the status register, drops the flags and the request. A legacy-disable input keeps the request low while another timer owns the interrupt line. The flags are still set while that input is high.

Top module: `periodic_irq_gen`

## Requirements
- R1: After synchronous reset, `per_pulse_o`, `stat_flags_o` and `irq_o` are all 0, and the tick counter starts from 0.
- R2: While `rate_sel` is 0, no event occurs, whatever `pie_en` is.
- R3: While `pie_en` is 0, no event occurs, whatever `rate_sel` is.
- R4: For rate codes 3 to 15, with a tick on every cycle, successive events are 2^(code-1) ticks apart: code 3 gives 4, code 6 gives 32 and code 15 gives 16384.
- R5: Code 1 behaves as code 8 (128 ticks) and code 2 behaves as code 9 (256 ticks).
- R6: An event fires only on a tick that brings the free-running count (ticks since reset, modulo 2^CNT_W) to a multiple of the current period. Changing the rate or the enable never resets the count, so the new rate takes effect at its own next boundary.
- R7: One cycle after the event tick, `per_pulse_o` is 1 for exactly one cycle and `stat_flags_o` becomes 2'b11. Bit 1 is the interrupt flag and bit 0 is the periodic flag. Both stay set until a clear.
- R8: An event taken while `legacy_off` is 0 drives `irq_o` to 1 from the next cycle, and `irq_o` stays 1 until a clear.
- R9: While `legacy_off` is 1, `irq_o` is 0, and an event taken in that state does not arm the request. The flags are still set.
- R10: `stat_clr` clears `stat_flags_o` and `irq_o` on the next cycle. If an event tick falls in the same cycle as the clear, the event wins and the flags read 2'b11.
- R11: In a cycle where `tick_en` is 0, the counter does not advance and no event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable for each 32.768 kHz tick |
| rate_sel | input | 4 | Rate code; 0 stops the generator |
| pie_en | input | 1 | Periodic interrupt enable |
| stat_clr | input | 1 | Status-clear strobe from a status read |
| legacy_off | input | 1 | Holds the interrupt request low |
| per_pulse_o | output | 1 | One-cycle pulse for each periodic event |
| stat_flags_o | output | 2 | Sticky flags: bit 1 interrupt, bit 0 periodic |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default 16-bit counter. With that width the slowest code, at 16384 ticks, is measured in full within the run. The run stays below one counter wrap, so the bench's plain tick count stands for the phase reference. A behavioural model, driven by the same tick, rate, enable, clear and legacy inputs, is compared with the outputs on every cycle. Random tick gaps and random clears put events in the same cycle as clears and move rate changes across period boundaries.

// File: rtl/prg_pkg.sv
package prg_pkg;

    localparam int RATE_W = 4;

    typedef logic [RATE_W-1:0] rate_code_t;

    typedef struct packed {
        logic irq_flag;
        logic per_flag;
    } stat_flags_t;

    // log2 of the period in ticks; codes 1 and 2 alias onto 8 and 9
    function automatic int unsigned period_shift(rate_code_t code);
        if (code == rate_code_t'(1))      return 7;
        else if (code == rate_code_t'(2)) return 8;
        else                              return int'(code) - 1;
    endfunction

endpackage

// File: rtl/prg_rate_decode.sv
module prg_rate_decode
    import prg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  rate_code_t       code_i,
    input  logic             pie_i,
    output logic             active_o,
    output logic [CNT_W-1:0] mask_o
);
    int unsigned shift;

    always_comb begin
        active_o = (code_i != '0) && pie_i;
        shift    = period_shift(code_i);
    end

    // one mask bit per counter bit: set below the period exponent
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign mask_o[i] = active_o && (shift > i);
    end

endmodule

// File: rtl/prg_phase_counter.sv
module prg_phase_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             active_i,
    input  logic [CNT_W-1:0] mask_i,
    output logic             hit_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = cnt_q + CNT_W'(1);
        hit_o   = tick_i && active_i && ((cnt_nxt & mask_i) == '0);
    end

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (tick_i) cnt_q <= cnt_nxt;
    end

    p_tick_advances_r11: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));

    p_no_tick_holds_r11: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(cnt_q));

    p_idle_no_hit_r2: assert property (@(posedge clk) disable iff (rst)
        !active_i |-> !hit_o);

endmodule

// File: rtl/prg_status_flags.sv
module prg_status_flags
    import prg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        evt_i,
    input  logic        clr_i,
    input  logic        legacy_i,
    output stat_flags_t flags_o,
    output logic        irq_line_o,
    output logic        pulse_o
);
    stat_flags_t flags_q;
    logic        irq_q;
    logic        pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            irq_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= evt_i;
            if (evt_i) begin
                flags_q.irq_flag <= 1'b1;
                flags_q.per_flag <= 1'b1;
                irq_q            <= irq_q | ~legacy_i;
            end else if (clr_i) begin
                flags_q <= '0;
                irq_q   <= 1'b0;
            end
        end
    end

    assign flags_o    = flags_q;
    assign irq_line_o = irq_q;
    assign pulse_o    = pulse_q;

    p_evt_sets_flags_r7: assert property (@(posedge clk) disable iff (rst)
        evt_i |=> (flags_o == 2'b11));

    p_clear_drops_r10: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !evt_i) |=> (flags_o == 2'b00 && !irq_line_o));

    p_legacy_no_arm_r9: assert property (@(posedge clk) disable iff (rst)
        (evt_i && legacy_i && !irq_q) |=> !irq_line_o);

    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !clr_i) |=> irq_line_o);

endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
    import prg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic [3:0]  rate_sel,
    input  logic        pie_en,
    input  logic        stat_clr,
    input  logic        legacy_off,
    output logic        per_pulse_o,
    output logic [1:0]  stat_flags_o,
    output logic        irq_o
);
    logic             active;
    logic [CNT_W-1:0] mask;
    logic             hit;
    stat_flags_t      flags;
    logic             irq_line;

    prg_rate_decode #(.CNT_W(CNT_W)) u_dec (
        .code_i   (rate_code_t'(rate_sel)),
        .pie_i    (pie_en),
        .active_o (active),
        .mask_o   (mask)
    );

    prg_phase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_en),
        .active_i (active),
        .mask_i   (mask),
        .hit_o    (hit)
    );

    prg_status_flags u_stat (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (hit),
        .clr_i      (stat_clr),
        .legacy_i   (legacy_off),
        .flags_o    (flags),
        .irq_line_o (irq_line),
        .pulse_o    (per_pulse_o)
    );

    assign stat_flags_o = flags;
    assign irq_o        = irq_line & ~legacy_off;

    p_stopped_no_evt_r3: assert property (@(posedge clk) disable iff (rst)
        (rate_sel == 4'd0 || !pie_en) |=> !per_pulse_o);

    p_pulse_flags_r7: assert property (@(posedge clk) disable iff (rst)
        per_pulse_o |-> (stat_flags_o == 2'b11));

endmodule

// File: tb/periodic_irq_gen_tb.sv
module periodic_irq_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic       pie_en = 1'b0;
    logic       stat_clr = 1'b0;
    logic       legacy_off = 1'b0;
    logic       per_pulse_o;
    logic [1:0] stat_flags_o;
    logic       irq_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    periodic_irq_gen u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .rate_sel(rate_sel),
        .pie_en(pie_en), .stat_clr(stat_clr), .legacy_off(legacy_off),
        .per_pulse_o(per_pulse_o), .stat_flags_o(stat_flags_o), .irq_o(irq_o)
    );

    // behavioural reference model
    int m_cnt = 0;
    int ticks = 0;
    bit m_pulse = 0;
    int m_flags = 0;
    bit m_irq = 0;

    function automatic int period_of(int code);
        if (code == 1) return 128;
        if (code == 2) return 256;
        return 1 << (code - 1);
    endfunction

    always @(posedge clk) begin
        bit hit;
        if (rst) begin
            m_cnt = 0; ticks = 0; m_pulse = 0; m_flags = 0; m_irq = 0;
        end else begin
            hit = tick_en && rate_sel != 0 && pie_en &&
                  (((m_cnt + 1) % period_of(rate_sel)) == 0);
            if (tick_en) begin
                m_cnt = (m_cnt + 1) % 65536;
                ticks++;
            end
            m_pulse = hit;
            if (hit) begin
                m_flags = 3;
                if (!legacy_off) m_irq = 1;
            end else if (stat_clr) begin
                m_flags = 0;
                m_irq = 0;
            end
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(per_pulse_o == m_pulse, "R6 pulse vs model", per_pulse_o, m_pulse);
            check(stat_flags_o == m_flags[1:0], "R7 flags vs model", stat_flags_o, m_flags);
            check(irq_o == (m_irq && !legacy_off), "R8 irq vs model", irq_o, m_irq && !legacy_off);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_pulse();
        @(negedge clk);
        while (!per_pulse_o) @(negedge clk);
    endtask

    task automatic gap(int code, int expv, string req);
        int n;
        @(posedge clk); #2;
        rate_sel = 4'(code);
        wait_pulse();
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!per_pulse_o);
        check(n == expv, req, n, expv);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seen;
        cyc(5);
        @(negedge clk);
        check(per_pulse_o == 0 && stat_flags_o == 0 && irq_o == 0, "R1 reset outputs",
              {per_pulse_o, stat_flags_o, irq_o}, 0);
        @(posedge clk); #2;
        rst = 1'b0;
        tick_en = 1'b1;

        // R2: rate 0 stops events
        pie_en = 1'b1; rate_sel = 4'd0;
        seen = 0;
        repeat (300) begin @(negedge clk); if (per_pulse_o) seen++; end
        check(seen == 0, "R2 no event with rate 0", seen, 0);

        // R3: enable low stops events
        @(posedge clk); #2;
        pie_en = 1'b0; rate_sel = 4'd3;
        seen = 0;
        repeat (300) begin @(negedge clk); if (per_pulse_o) seen++; end
        check(seen == 0, "R3 no event with enable low", seen, 0);

        @(posedge clk); #2;
        pie_en = 1'b1;
        gap(3, 4, "R4 code 3 gap");
        gap(6, 32, "R4 code 6 gap");
        gap(1, 128, "R5 code 1 alias");
        gap(2, 256, "R5 code 2 alias");

        // R6: alignment after a mid-phase rate change
        cyc(3);
        rate_sel = 4'd5;
        wait_pulse();
        check((ticks % 16) == 0, "R6 event on 16-tick boundary", ticks % 16, 0);
        // R7: pulse is one cycle, flags sticky
        @(negedge clk);
        check(per_pulse_o == 0, "R7 pulse one cycle", per_pulse_o, 0);
        check(stat_flags_o == 2'b11, "R7 flags sticky", stat_flags_o, 3);

        // R8/R10: request holds without clear, then clear drops it
        @(posedge clk); #2;
        pie_en = 1'b0;
        cyc(40);
        @(negedge clk);
        check(irq_o == 1, "R8 irq held until clear", irq_o, 1);
        @(posedge clk); #2;
        stat_clr = 1'b1;
        @(posedge clk); #2;
        stat_clr = 1'b0;
        @(negedge clk);
        check(stat_flags_o == 0 && irq_o == 0, "R10 clear drops flags and irq",
              {stat_flags_o, irq_o}, 0);

        // R9: legacy disable keeps request low, flags still set
        @(posedge clk); #2;
        legacy_off = 1'b1; pie_en = 1'b1; rate_sel = 4'd3;
        wait_pulse();
        check(irq_o == 0, "R9 irq low under legacy disable", irq_o, 0);
        check(stat_flags_o == 2'b11, "R9 flags still set", stat_flags_o, 3);
        @(posedge clk); #2;
        pie_en = 1'b0;
        cyc(2);
        legacy_off = 1'b0;
        @(negedge clk);
        check(irq_o == 0, "R9 event under legacy did not arm irq", irq_o, 0);

        // R10: event wins over a clear in the same cycle
        @(posedge clk); #2;
        pie_en = 1'b1; stat_clr = 1'b1;
        repeat (3) begin
            wait_pulse();
            check(stat_flags_o == 2'b11, "R10 event wins over clear", stat_flags_o, 3);
        end
        @(posedge clk); #2;
        stat_clr = 1'b0;

        // R11: no tick, no event
        tick_en = 1'b0;
        seen = 0;
        repeat (100) begin @(negedge clk); if (per_pulse_o) seen++; end
        check(seen == 0, "R11 no event without tick", seen, 0);

        // random tick gaps, clears, rate changes against the model
        for (int k = 0; k < 3000; k++) begin
            @(posedge clk); #2;
            tick_en  = ($urandom % 3) == 0;
            stat_clr = ($urandom % 13) == 0;
            legacy_off = ($urandom % 29) == 0;
            if (($urandom % 400) == 0) rate_sel = 4'($urandom % 8);
            if (($urandom % 500) == 0) pie_en = ~pie_en;
        end
        @(posedge clk); #2;
        tick_en = 1'b1; legacy_off = 1'b0; stat_clr = 1'b0; pie_en = 1'b1;

        gap(15, 16384, "R4 code 15 gap");

        cyc(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule